// File: doc/BRIEF.md
# Rotating-Parity Block Array Controller

The block places logical blocks across five small on-chip storage arrays that act as disks. Every stripe carries four data blocks and one parity block. The parity block is the bitwise XOR of the four data blocks. The disk that holds parity moves from one stripe to the next, so writes to different stripes do not all land on the same parity disk. A host issues one request at a time through a valid/ready port. Each request reads or writes one logical block. Read data returns on a one-cycle response strobe.

A write to a single block never touches the other data disks of its stripe. The block reads the old data and the old parity, then writes the new data and a parity equal to old parity XOR old data XOR new data. A failed-disk input marks one disk as unusable. A read aimed at that disk is rebuilt from the four surviving blocks of the stripe. A write aimed at it folds the new data into parity only. A write whose parity disk has failed stores the data alone.

Top module: `raid5_engine`

## Requirements
- R1: After reset every block of every disk holds zero, `req_ready` is high and `rsp_valid` is low.
- R2: Logical address `lba` maps to stripe `s = lba / 4` and data slot `k = lba % 4`. The parity disk of stripe `s` is `4 - (s % 5)`. Data slot `k` lives on disk `(parity + 1 + k) % 5`. A `fail_disk` value of 5, 6 or 7 means that no disk has failed.
- R3: A read whose target disk is not failed performs one physical read and no physical write. It returns the last data written to that address on a `rsp_valid` pulse that lasts exactly one cycle.
- R4: A write with no failed disk in its stripe performs exactly two physical reads (old data, old parity) and two physical writes (new data, new parity). The new parity is old parity ^ old data ^ new data, so the XOR of all five blocks of the stripe is unchanged.
- R5: A read whose target disk equals `fail_disk` returns the XOR of the four other blocks of its stripe and writes nothing.
- R6: A write whose target data disk equals `fail_disk` leaves that disk unchanged. It reads the three surviving data blocks and writes their XOR with the new data to the parity disk, which is its only physical write.
- R7: A write whose stripe parity disk equals `fail_disk` writes the data block only and leaves the parity block unchanged.
- R8: `req_ready` drops in the cycle after a request is accepted. It stays low until the final physical write or the read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_lba | input | LBA_W | Logical block address |
| req_wdata | input | BLK_W | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | BLK_W | Read data |
| fail_disk | input | 3 | Index of failed disk; 5 to 7 means none |

## Verification
The assertions check several properties on every request, using local access counters. They check the number of physical reads and writes for each request type. They check that a healthy write leaves the stripe XOR unchanged, that the response strobe lasts one cycle, and that ready drops after acceptance. The bench alone shows where data and parity sit, and only through ports. It degrades a write and then reads the stale or rebuilt value with the failure cleared and set. It also confirms after each healthy write that every block of the stripe can be rebuilt from parity.

// File: rtl/raid5_engine.sv
module raid5_engine #(
  parameter int BLK_W   = 32,
  parameter int STRIPES = 8,
  localparam int SW     = (STRIPES > 1) ? $clog2(STRIPES) : 1,
  localparam int LBA_W  = SW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_wr,
  input  logic [LBA_W-1:0] req_lba,
  input  logic [BLK_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BLK_W-1:0] rsp_rdata,
  input  logic [2:0]       fail_disk
);
  localparam int NDISK = 5;

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_RDP, S_ACC, S_WRD, S_WRP} st_t;
  typedef enum logic [2:0] {OP_RD, OP_RB, OP_WR, OP_WR_DFAIL, OP_WR_PFAIL} op_t;

  function automatic logic [2:0] par_disk(input logic [SW-1:0] s);
    return 3'(32'd4 - (32'(s) % 32'd5));
  endfunction

  function automatic logic [2:0] dat_disk(input logic [2:0] p, input logic [1:0] k);
    return 3'((32'(p) + 32'(k) + 32'd1) % 32'd5);
  endfunction

  logic [BLK_W-1:0] mem [NDISK][STRIPES];
  st_t              st;
  op_t              op;
  logic [LBA_W-1:0] lba_q;
  logic [BLK_W-1:0] wdata_q, old_d, old_p, acc;
  logic [2:0]       j;

  wire [SW-1:0] s_q   = lba_q[LBA_W-1:2];
  wire [2:0]    pd    = par_disk(s_q);
  wire [2:0]    dd    = dat_disk(pd, lba_q[1:0]);
  wire [SW-1:0] s_in  = req_lba[LBA_W-1:2];
  wire [2:0]    pd_in = par_disk(s_in);
  wire [2:0]    dd_in = dat_disk(pd_in, req_lba[1:0]);

  wire accept = req_valid && req_ready;
  wire use_j  = (j != dd) && (op == OP_RB || j != pd);
  wire [BLK_W-1:0] acc_nxt = use_j ? (acc ^ mem[j][s_q]) : acc;

  assign req_ready = (st == S_IDLE);

  op_t op_in;
  always_comb begin
    if (req_wr)
      op_in = (fail_disk == dd_in) ? OP_WR_DFAIL :
              (fail_disk == pd_in) ? OP_WR_PFAIL : OP_WR;
    else
      op_in = (fail_disk == dd_in) ? OP_RB : OP_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op        <= OP_RD;
      lba_q     <= '0;
      wdata_q   <= '0;
      old_d     <= '0;
      old_p     <= '0;
      acc       <= '0;
      j         <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int d = 0; d < NDISK; d++)
        for (int s = 0; s < STRIPES; s++)
          mem[d][s] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op      <= op_in;
          lba_q   <= req_lba;
          wdata_q <= req_wdata;
          acc     <= '0;
          j       <= '0;
          case (op_in)
            OP_RD, OP_WR:          st <= S_RDD;
            OP_RB, OP_WR_DFAIL:    st <= S_ACC;
            default:               st <= S_WRD;
          endcase
        end
        S_RDD: begin
          old_d <= mem[dd][s_q];
          if (op == OP_RD) begin
            rsp_rdata <= mem[dd][s_q];
            rsp_valid <= 1'b1;
            st        <= S_IDLE;
          end else begin
            st <= S_RDP;
          end
        end
        S_RDP: begin
          old_p <= mem[pd][s_q];
          st    <= S_WRD;
        end
        S_ACC: begin
          acc <= acc_nxt;
          if (j == 3'(NDISK - 1)) begin
            if (op == OP_RB) begin
              rsp_rdata <= acc_nxt;
              rsp_valid <= 1'b1;
              st        <= S_IDLE;
            end else begin
              st <= S_WRP;
            end
          end else begin
            j <= j + 3'd1;
          end
        end
        S_WRD: begin
          mem[dd][s_q] <= wdata_q;
          st <= (op == OP_WR_PFAIL) ? S_IDLE : S_WRP;
        end
        S_WRP: begin
          mem[pd][s_q] <= ((op == OP_WR_DFAIL) ? acc : (old_p ^ old_d)) ^ wdata_q;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [2:0]       rd_n, wr_n;
  logic             busy_q;
  logic [BLK_W-1:0] xor_q, xor_in, xor_before;

  wire phys_rd = (st == S_RDD) || (st == S_RDP) || (st == S_ACC && use_j);
  wire phys_wr = (st == S_WRD) || (st == S_WRP);
  wire done    = (st == S_IDLE) && busy_q;

  always_comb begin
    xor_q  = '0;
    xor_in = '0;
    for (int d = 0; d < NDISK; d++) begin
      xor_q  = xor_q  ^ mem[d][s_q];
      xor_in = xor_in ^ mem[d][s_in];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n       <= '0;
      wr_n       <= '0;
      busy_q     <= 1'b0;
      xor_before <= '0;
    end else begin
      busy_q <= (st != S_IDLE);
      if (accept) begin
        rd_n       <= '0;
        wr_n       <= '0;
        xor_before <= xor_in;
      end else begin
        rd_n <= rd_n + 3'(phys_rd);
        wr_n <= wr_n + 3'(phys_wr);
      end
    end
  end

  a_r2_disks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (dd != pd && dd < 3'd5 && pd < 3'd5));
  a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_RD) |-> (rd_n == 3'd1 && wr_n == 3'd0));
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r4_delta_accesses: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_WR) |-> (rd_n == 3'd2 && wr_n == 3'd2));
  a_r4_stripe_xor_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_WR) |-> (xor_q == xor_before));
  a_r5_rebuild_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_RB) |-> (rd_n == 3'd4 && wr_n == 3'd0));
  a_r6_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_WR_DFAIL) |-> (rd_n == 3'd3 && wr_n == 3'd1));
  a_r7_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_WR_PFAIL) |-> (rd_n == 3'd0 && wr_n == 3'd1));
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r8_idle_at_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

// File: tb/sim_raid5_engine.sv
module sim_raid5_engine;
  localparam int BLK_W = 32;
  localparam int LBA_W = 5;
  localparam int NV    = 16;
  localparam logic [2:0] NOF = 3'd7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_wr = 1'b0;
  logic [LBA_W-1:0] req_lba = '0;
  logic [BLK_W-1:0] req_wdata = '0;
  logic             rsp_valid;
  logic [BLK_W-1:0] rsp_rdata;
  logic [2:0]       fail_disk = NOF;

  int total = 0;
  int bad = 0;
  logic [BLK_W-1:0] shadow [32];

  always #10 clk = ~clk;

  raid5_engine #(.BLK_W(BLK_W), .STRIPES(8)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_wr, .req_lba,
    .req_wdata, .rsp_valid, .rsp_rdata, .fail_disk);

  // {write, fail, lba, data}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, NOF,  5'd0,  32'h1111_0000},
    {1'b1, NOF,  5'd1,  32'h2222_0101},
    {1'b1, NOF,  5'd6,  32'h3c3c_5a5a},
    {1'b1, NOF,  5'd9,  32'hdead_beef},
    {1'b1, NOF,  5'd15, 32'h0f0f_f0f0},
    {1'b1, NOF,  5'd16, 32'h8000_0001},
    {1'b0, NOF,  5'd0,  32'h0},
    {1'b0, 3'd1, 5'd1,  32'h0},
    {1'b0, 3'd1, 5'd6,  32'h0},
    {1'b0, 3'd4, 5'd2,  32'h0},
    {1'b1, NOF,  5'd0,  32'hcafe_f00d},
    {1'b0, 3'd0, 5'd0,  32'h0},
    {1'b0, 3'd1, 5'd16, 32'h0},
    {1'b0, 3'd0, 5'd15, 32'h0},
    {1'b1, NOF,  5'd12, 32'h1234_5678},
    {1'b0, 3'd5, 5'd12, 32'h0}
  };

  function automatic logic [2:0] pdisk(input int s);
    return 3'(4 - (s % 5));
  endfunction
  function automatic logic [2:0] ddisk(input int s, input int k);
    return 3'((int'(pdisk(s)) + 1 + k) % 5);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [BLK_W-1:0] act,
                       input logic [BLK_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60; i++) begin
      if (req_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic wr, input logic [2:0] f, input logic [LBA_W-1:0] a,
                       input logic [BLK_W-1:0] d, output logic [BLK_W-1:0] rd);
    rd = '0;
    @(negedge clk);
    wait_ready();
    fail_disk = f;
    req_wr    = wr;
    req_lba   = a;
    req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      wait_ready();
    end else begin
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (rsp_valid) begin
          rd = rsp_rdata;
          break;
        end
      end
    end
  endtask

  task automatic check_stripe(input int s);
    logic [BLK_W-1:0] r;
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, ddisk(s, k), 5'(s * 4 + k), '0, r);
      check(r == shadow[s * 4 + k], "R4 stripe rebuild", r, shadow[s * 4 + k]);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [BLK_W-1:0] r;
    for (int i = 0; i < 32; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    issue(1'b0, NOF, 5'd31, '0, r);
    check(r == '0, "R1 zero contents", r, '0);

    for (int v = 0; v < NV; v++) begin
      logic             vw;
      logic [2:0]       vf;
      logic [LBA_W-1:0] va;
      logic [BLK_W-1:0] vd;
      {vw, vf, va, vd} = VEC[v];
      issue(vw, vf, va, vd, r);
      if (vw) begin
        shadow[va] = vd;
        check_stripe(int'(va) / 4);
      end else if (vf == ddisk(int'(va) / 4, int'(va) % 4)) begin
        check(r == shadow[va], "R5 rebuilt read", r, shadow[va]);
      end else begin
        check(r == shadow[va], "R3 direct read", r, shadow[va]);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R3 response one cycle", 32'(rsp_valid), 32'd0);
      end
    end

    // R8: ready low in the cycle after acceptance
    @(negedge clk);
    wait_ready();
    fail_disk = NOF; req_wr = 1'b1; req_lba = 5'd3; req_wdata = 32'h5555_aaaa;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 32'd0);
    wait_ready();
    check(req_ready == 1'b1, "R8 ready after final write", 32'(req_ready), 32'd1);
    shadow[3] = 32'h5555_aaaa;
    check_stripe(0);

    // R6: stripe 5, lba 21 lives on disk 1
    issue(1'b1, NOF, 5'd21, 32'haaaa_0001, r);
    issue(1'b1, ddisk(5, 1), 5'd21, 32'hbbbb_0002, r);
    issue(1'b0, NOF, 5'd21, '0, r);
    check(r == 32'haaaa_0001, "R6 failed data disk untouched", r, 32'haaaa_0001);
    issue(1'b0, ddisk(5, 1), 5'd21, '0, r);
    check(r == 32'hbbbb_0002, "R6 new data held in parity", r, 32'hbbbb_0002);

    // R7: stripe 6, lba 25, parity on disk 3
    issue(1'b1, NOF, 5'd25, 32'hcccc_0003, r);
    issue(1'b1, pdisk(6), 5'd25, 32'hdddd_0004, r);
    issue(1'b0, NOF, 5'd25, '0, r);
    check(r == 32'hdddd_0004, "R7 data written", r, 32'hdddd_0004);
    issue(1'b0, ddisk(6, 1), 5'd25, '0, r);
    check(r == 32'hcccc_0003, "R7 parity left unchanged", r, 32'hcccc_0003);

    // R2: stripe 7, lba 30 on disk 0, parity on disk 2; index 6 means no failure
    issue(1'b1, NOF, 5'd30, 32'h7777_0005, r);
    issue(1'b1, 3'd0, 5'd30, 32'h7777_0006, r);
    issue(1'b0, 3'd6, 5'd30, '0, r);
    check(r == 32'h7777_0005, "R2 block placed on disk 0", r, 32'h7777_0005);
    issue(1'b1, 3'd2, 5'd29, 32'h2929_0007, r);
    issue(1'b0, 3'd5, 5'd29, '0, r);
    check(r == 32'h2929_0007, "R2 parity disk 2 skipped for data", r, 32'h2929_0007);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule